// File: doc/BRIEF.md
# Prescaled Down-Counting Interval Timer

This block is a small register-mapped countdown timer that gives a processor a periodic or one-shot interrupt. Software programs a prescale value, a reload period and a starting count, then turns the timer on through a control register. The count steps down by one on every prescaler tick. When it takes its last step from one to zero, the timer sets a sticky expiry flag and, if auto-reload is on, refills the count from the period register so that counting goes on.

The starting count and the reload period are separate registers. This lets the first interval differ from all later ones. For example, a start of 0x4000 with a period of 0x2000 gives one long interval and then a steady shorter rhythm. The interrupt line is a level output. It stays high until the service routine writes a one to the flag bit. A power bit in the control register freezes both the prescaler and the counter without losing their contents.

Top module: `ctmr_top`

## Requirements
- R1: After reset, the control, period, scale and count registers all read zero and `irq` is low.
- R2: The register map is fixed. Address 0 is control, address 1 is period, address 2 is scale and address 3 is count. `rdata` gives the addressed register in the same cycle, zero-extended. In control, bit0 is power, bit1 is enable, bit2 is auto-reload and bit3 is the flag.
- R3: When running, the count drops by one per tick and never rises except by a write or a reload. With a scale of 0, the flag sets exactly N clocks after a count write of N.
- R4: A tick occurs once every (scale+1) clocks, measured from the most recent count write.
- R5: With control bit2 set, the expiry step (count 1 to 0) loads the period into the count. Each later interval is then the period's number of ticks.
- R6: The flag (control bit3) sets on expiry. It stays set until software writes control with bit3 = 1. A control write with bit3 = 0 leaves it unchanged.
- R7: `irq` is high only while the flag is set and control bit1 (enable) is 1.
- R8: The count and prescaler move only when control bit0 (power) and bit1 (enable) are both 1. Otherwise they hold their values.
- R9: With control bit2 clear, the count stays at zero after expiry and no further expiry occurs.
- R10: A count write takes priority over a decrement, reload or expiry in the same cycle, and it restarts the prescaler phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register select |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data of the addressed register |
| irq | output | 1 | Level interrupt: flag and enable |

## Verification
The assertions assume that the write port is driven with stable, known values. They also assume that at most one register is written per cycle, since the address selects a single target. The stimulus changes `wr_en`, `addr` and `wdata` only just after a rising edge and holds them for one full cycle per write. It also writes the count last when arming the timer, so each interval is measured from a known prescaler phase. Count writes are placed on the exact cycle an expiry would fall due, to exercise the write-over-expiry priority.

// File: rtl/ctmr_pkg.sv
package ctmr_pkg;

    typedef enum logic [1:0] {
        REG_CTRL   = 2'd0,
        REG_PERIOD = 2'd1,
        REG_SCALE  = 2'd2,
        REG_COUNT  = 2'd3
    } ctmr_reg_e;

    localparam int CTRL_PWR  = 0;
    localparam int CTRL_EN   = 1;
    localparam int CTRL_AR   = 2;
    localparam int CTRL_FLAG = 3;
    localparam int CTRL_W    = 4;

    typedef struct packed {
        logic flag;
        logic autoreload;
        logic enable;
        logic power;
    } ctmr_ctrl_t;

    typedef struct packed {
        logic ctrl;
        logic period;
        logic scale;
        logic count;
    } ctmr_wsel_t;

    function automatic ctmr_wsel_t ctmr_decode(input logic wr, input logic [1:0] a);
        ctmr_wsel_t s;
        s.ctrl   = wr && (a == REG_CTRL);
        s.period = wr && (a == REG_PERIOD);
        s.scale  = wr && (a == REG_SCALE);
        s.count  = wr && (a == REG_COUNT);
        return s;
    endfunction

endpackage

// File: rtl/ctmr_regs.sv
module ctmr_regs
    import ctmr_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 32,
    parameter int SCL_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  ctmr_wsel_t        wsel,
    input  logic [DATA_W-1:0] wdata,
    input  logic              expire,
    output ctmr_ctrl_t        ctrl,
    output logic [CNT_W-1:0]  period,
    output logic [SCL_W-1:0]  scale
);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl.power      <= 1'b0;
            ctrl.enable     <= 1'b0;
            ctrl.autoreload <= 1'b0;
        end else if (wsel.ctrl) begin
            ctrl.power      <= wdata[CTRL_PWR];
            ctrl.enable     <= wdata[CTRL_EN];
            ctrl.autoreload <= wdata[CTRL_AR];
        end
    end

    // expiry wins over a same-cycle acknowledge so no event is lost
    always_ff @(posedge clk) begin
        if (rst)
            ctrl.flag <= 1'b0;
        else if (expire)
            ctrl.flag <= 1'b1;
        else if (wsel.ctrl && wdata[CTRL_FLAG])
            ctrl.flag <= 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            period <= '0;
            scale  <= '0;
        end else begin
            if (wsel.period) period <= wdata[CNT_W-1:0];
            if (wsel.scale)  scale  <= wdata[SCL_W-1:0];
        end
    end

endmodule

// File: rtl/ctmr_prescale.sv
module ctmr_prescale #(
    parameter int SCL_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             restart,
    input  logic [SCL_W-1:0] scale,
    output logic             tick
);

    logic [SCL_W-1:0] phase;

    // >= keeps the prescaler safe when scale is lowered below the phase
    assign tick = run && (phase >= scale);

    always_ff @(posedge clk) begin
        if (rst || restart)
            phase <= '0;
        else if (run)
            phase <= tick ? '0 : phase + 1'b1;
    end

endmodule

// File: rtl/ctmr_counter.sv
module ctmr_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             autoreload,
    input  logic [CNT_W-1:0] period,
    output logic [CNT_W-1:0] count,
    output logic             expire
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    assign expire = tick && !load && (count == ONE);

    always_ff @(posedge clk) begin
        if (rst)
            count <= '0;
        else if (load)
            count <= load_val;
        else if (tick && (count != '0)) begin
            if (count == ONE)
                count <= autoreload ? period : '0;
            else
                count <= count - 1'b1;
        end
    end

endmodule

// File: rtl/ctmr_top.sv
module ctmr_top
    import ctmr_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 32,
    parameter int SCL_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [1:0]        addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              irq
);

    ctmr_wsel_t       wsel;
    ctmr_ctrl_t       ctrl;
    logic [CNT_W-1:0] period;
    logic [SCL_W-1:0] scale;
    logic [CNT_W-1:0] count;
    logic             tick;
    logic             expire;
    logic             run;

    assign wsel = ctmr_decode(wr_en, addr);
    assign run  = ctrl.power && ctrl.enable;

    ctmr_regs #(.DATA_W(DATA_W), .CNT_W(CNT_W), .SCL_W(SCL_W)) u_regs (
        .clk    (clk),
        .rst    (rst),
        .wsel   (wsel),
        .wdata  (wdata),
        .expire (expire),
        .ctrl   (ctrl),
        .period (period),
        .scale  (scale)
    );

    ctmr_prescale #(.SCL_W(SCL_W)) u_pre (
        .clk     (clk),
        .rst     (rst),
        .run     (run),
        .restart (wsel.count),
        .scale   (scale),
        .tick    (tick)
    );

    ctmr_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk        (clk),
        .rst        (rst),
        .tick       (tick),
        .load       (wsel.count),
        .load_val   (wdata[CNT_W-1:0]),
        .autoreload (ctrl.autoreload),
        .period     (period),
        .count      (count),
        .expire     (expire)
    );

    always_comb begin
        unique case (addr)
            REG_CTRL:   rdata = DATA_W'(ctrl);
            REG_PERIOD: rdata = DATA_W'(period);
            REG_SCALE:  rdata = DATA_W'(scale);
            default:    rdata = DATA_W'(count);
        endcase
    end

    assign irq = ctrl.flag && ctrl.enable;

endmodule

// File: rtl/ctmr_chk.sv
module ctmr_chk #(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic [1:0]        addr,
    input logic [DATA_W-1:0] wdata,
    input logic [CNT_W-1:0]  count,
    input logic              flag,
    input logic              power,
    input logic              enable,
    input logic              irq
);

    logic cnt_wr;
    logic ack_wr;
    assign cnt_wr = wr_en && (addr == 2'd3);
    assign ack_wr = wr_en && (addr == 2'd0) && wdata[3];

    assert_load_wins_R10: assert property (@(posedge clk) disable iff (rst)
        cnt_wr |=> count == $past(wdata[CNT_W-1:0]));

    assert_frozen_R8: assert property (@(posedge clk) disable iff (rst)
        (!(power && enable) && !cnt_wr) |=> $stable(count));

    assert_flag_holds_R6: assert property (@(posedge clk) disable iff (rst)
        (flag && !ack_wr) |=> flag);

    assert_irq_gated_R7: assert property (@(posedge clk) disable iff (rst)
        !enable |-> !irq);

    assert_zero_rests_R9: assert property (@(posedge clk) disable iff (rst)
        (count == '0 && !cnt_wr) |=> count == '0);

    assert_no_climb_R3: assert property (@(posedge clk) disable iff (rst)
        (count > CNT_W'(1) && !cnt_wr) |=> count <= $past(count));

endmodule

bind ctmr_top ctmr_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
    .clk    (clk),
    .rst    (rst),
    .wr_en  (wr_en),
    .addr   (addr),
    .wdata  (wdata),
    .count  (count),
    .flag   (ctrl.flag),
    .power  (ctrl.power),
    .enable (ctrl.enable),
    .irq    (irq)
);

// File: tb/ctmr_top_tb.sv
module ctmr_top_tb;

    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          wr_en = 1'b0;
    logic [1:0]    addr = 2'd0;
    logic [DW-1:0] wdata = '0;
    logic [DW-1:0] rdata;
    logic          irq;

    typedef struct {
        bit          is_irq;
        logic [DW-1:0] exp;
        string       req;
    } item_t;

    item_t q[$];
    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #5 clk = ~clk;

    ctmr_top #(.DATA_W(DW), .CNT_W(DW), .SCL_W(8)) u_dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .irq(irq)
    );

    // monitor: compares queued expectations between edges
    always @(negedge clk) begin
        while (q.size() > 0) begin
            item_t it;
            it = q.pop_front();
            checks++;
            if (it.is_irq) begin
                if (irq !== it.exp[0]) begin
                    errors++;
                    $display("FAIL %s irq actual %0b expected %0b", it.req, irq, it.exp[0]);
                end
            end else if (rdata !== it.exp) begin
                errors++;
                $display("FAIL %s rdata actual 0x%0h expected 0x%0h", it.req, rdata, it.exp);
            end
        end
    end

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [DW-1:0] d);
        wr_en = 1'b1;
        addr  = a;
        wdata = d;
        @(posedge clk);
        #1;
        wr_en = 1'b0;
    endtask

    task automatic exp_irq(input bit v, input string req);
        item_t it;
        it.is_irq = 1'b1;
        it.exp    = DW'(v);
        it.req    = req;
        q.push_back(it);
    endtask

    task automatic exp_rd(input logic [1:0] a, input logic [DW-1:0] v, input string req);
        item_t it;
        addr      = a;
        it.is_irq = 1'b0;
        it.exp    = v;
        it.req    = req;
        q.push_back(it);
        idle(1);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 10);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        rst = 1'b0;

        // R1: reset state, R2: map
        exp_irq(0, "R1");
        exp_rd(2'd0, 0, "R1");
        exp_rd(2'd1, 0, "R1");
        exp_rd(2'd2, 0, "R1");
        exp_rd(2'd3, 0, "R1");

        // first interval from count, later ones from period
        wr(2'd2, 0);
        wr(2'd1, 3);
        wr(2'd0, 32'h7);
        wr(2'd3, 5);
        idle(4);
        exp_irq(0, "R3");
        idle(1);
        exp_irq(1, "R3");
        wr(2'd0, 32'hF);          // acknowledge, keep running
        exp_irq(0, "R6");
        idle(1);
        exp_irq(0, "R5");
        idle(1);
        exp_irq(1, "R5");

        // sticky flag and gating
        idle(3);
        exp_irq(1, "R6");
        wr(2'd0, 32'h5);          // enable off, bit3 = 0
        exp_irq(0, "R7");
        exp_rd(2'd0, 32'hD, "R6");
        exp_rd(2'd1, 3, "R2");
        exp_rd(2'd2, 0, "R2");
        wr(2'd0, 32'h8);
        exp_rd(2'd0, 0, "R6");

        // prescaler: scale 2, count 4, one-shot
        wr(2'd2, 2);
        wr(2'd0, 32'h3);
        wr(2'd3, 4);
        idle(11);
        exp_irq(0, "R4");
        idle(1);
        exp_irq(1, "R4");
        idle(20);
        exp_rd(2'd3, 0, "R9");
        exp_irq(1, "R9");
        wr(2'd0, 32'hB);
        idle(30);
        exp_irq(0, "R9");

        // low power freezes counting
        wr(2'd2, 0);
        wr(2'd0, 32'h2);
        wr(2'd3, 3);
        idle(10);
        exp_rd(2'd3, 3, "R8");
        exp_irq(0, "R8");
        wr(2'd0, 32'h3);
        idle(2);
        exp_irq(0, "R8");
        idle(1);
        exp_irq(1, "R8");
        wr(2'd0, 32'hB);

        // count write over a due expiry, and phase restart
        wr(2'd3, 2);
        idle(1);
        wr(2'd3, 10);
        exp_irq(0, "R10");
        exp_rd(2'd3, 10, "R10");
        wr(2'd2, 3);
        wr(2'd3, 2);
        idle(7);
        exp_irq(0, "R10");
        idle(1);
        exp_irq(1, "R10");

        idle(2);
        finish_run();
    end

endmodule